// File: doc/BRIEF.md
# Segment-Mapped Address Translation Front End

This block sits in front of the paged translation lookaside buffer and decides how a virtual address becomes physical. When translation is switched off globally, the address passes straight through with every permission granted. When translation is on, a kernel-mode access whose 256 MB segment (the top four address bits) is marked as directly mapped takes a 4-bit physical base for that segment from one of two packed base registers. That base replaces the top four bits and the lower 28 bits are kept. Every other access, including every user-mode access, is handed to the paged path.

The block takes one request at a time. It is ready only in its idle state. A pass-through or direct-mapped request is answered one cycle after it is accepted. A paged request is held stable on the TLB request port until the TLB returns a done pulse, and the TLB's address, permissions and fault are then returned. The controller is a three-state machine:

- ST_IDLE: ready for a request.
- ST_WALK: waiting on the TLB.
- ST_DONE: the response is valid for one cycle.

Its transitions are:

- IDLE→DONE on an accepted bypass request.
- IDLE→WALK on an accepted paged request.
- WALK→WALK while the done signal is low.
- WALK→DONE when done is high.
- DONE→IDLE always.

Top module: `seg_xlate_front`

## Requirements
- R1: Translation is on when bit 2 or bit 3 of `gc_cfg` is set; other bits of `gc_cfg` have no effect. When it is off, every request, user or kernel, responds with `rsp_paddr` equal to `req_vaddr`, `rsp_perm` = 3'b111 (bit 2 execute, bit 1 write, bit 0 read), `rsp_fault` = 0 and `rsp_from_tlb` = 0.
- R2: With translation on, a request is directly mapped exactly when `req_user` = 0 and `mm_cfg[req_vaddr[31:28]]` = 1; such a request never reaches the TLB.
- R3: For a directly mapped request with segment s, the base nibble is `seg_base_lo[4*s+3:4*s]` for s < 8 and `seg_base_hi[4*(s-8)+3:4*(s-8)]` for s ≥ 8. `rsp_paddr` = {nibble, `req_vaddr[27:0]`}, `rsp_perm` = 3'b111, and `rsp_fault` = 0.
- R4: With translation on, a request with `req_user` = 1 goes to the TLB whatever `mm_cfg` holds.
- R5: With translation on, a kernel request whose segment bit in `mm_cfg` is clear goes to the TLB.
- R6: A bypass request (R1 or R2) accepted on a clock edge gives `rsp_valid` = 1, `rsp_from_tlb` = 0 for exactly the following cycle. It never raises `tlb_req`.
- R7: A paged request accepted on an edge raises `tlb_req` from the next cycle until the edge where `tlb_done` is sampled high. While it waits, `tlb_vaddr`, `tlb_user` and `tlb_kind` hold the accepted request. In the cycle after that edge, `rsp_valid` = 1 and `rsp_from_tlb` = 1, and `rsp_paddr`, `rsp_perm` and `rsp_fault` carry the sampled `tlb_paddr`, `tlb_perm` and `tlb_fault`.
- R8: After reset, `req_ready` = 1 and `rsp_valid` = `tlb_req` = 0. `req_ready` is 1 only in ST_IDLE. A `req_valid` seen while `req_ready` = 0 is ignored and produces no response.
- R9: A `tlb_done` pulse while no paged request is waiting has no effect: no response, and the block stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute |
| gc_cfg | input | 32 | Global configuration word; bits 2 and 3 enable translation |
| mm_cfg | input | 16 | Per-segment direct-mapping enables, bit s for segment s |
| seg_base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| seg_base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| tlb_req | output | 1 | Paged lookup pending |
| tlb_vaddr | output | 32 | Address of the pending lookup |
| tlb_user | output | 1 | Mode of the pending lookup |
| tlb_kind | output | 2 | Access type of the pending lookup |
| tlb_done | input | 1 | TLB result valid |
| tlb_paddr | input | 32 | TLB physical address |
| tlb_perm | input | 3 | TLB permissions {x,w,r} |
| tlb_fault | input | 1 | TLB fault |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions {x,w,r} |
| rsp_fault | output | 1 | Fault indication |
| rsp_from_tlb | output | 1 | 1 when the result came from the paged path |

## Verification
The assertions check the following on every cycle:

- The response is a single-cycle pulse that is always followed by a return to ready.
- A waiting TLB request stays raised with a stable address.
- Bypass responses always carry full permissions and no fault.
- Each accepted request is routed the way its mode, `gc_cfg` bits and segment bit say.
- A TLB-sourced response matches the result sampled on the done edge.

Some behaviours only the bench's scenarios can show, by comparing against a behavioural model:

- The base nibble is picked from the correct register and position, including the segment 7/8 boundary.
- Configuration bits other than bits 2 and 3 are ignored.
- Requests raised during a walk are dropped.
- Stray done pulses while idle are harmless.

// File: rtl/xl_pkg.sv
package xl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    localparam perm_t PERM_ALL = '{x: 1'b1, w: 1'b1, r: 1'b1};

endpackage

// File: rtl/seg_base_pick.sv
module seg_base_pick #(
    parameter int SEG_W = 4,
    parameter int REG_W = 32
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [REG_W-1:0] base_lo,
    input  logic [REG_W-1:0] base_hi,
    output logic [SEG_W-1:0] nibble
);
    localparam int NSEG    = 1 << SEG_W;
    localparam int PER_REG = REG_W / SEG_W;

    logic [SEG_W-1:0] cand [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_cand
        if (g < PER_REG) begin : g_lo
            assign cand[g] = base_lo[g*SEG_W +: SEG_W];
        end else begin : g_hi
            assign cand[g] = base_hi[(g-PER_REG)*SEG_W +: SEG_W];
        end
    end

    assign nibble = cand[seg];

endmodule

// File: rtl/seg_decode.sv
module seg_decode #(
    parameter int          ADDR_W  = 32,
    parameter int          SEG_W   = 4,
    parameter int          REG_W   = 32,
    parameter int          CFG_W   = 32,
    parameter logic [31:0] EN_MASK = 32'h0000_000C
) (
    input  logic [ADDR_W-1:0]       vaddr,
    input  logic                    user,
    input  logic [CFG_W-1:0]        gc_cfg,
    input  logic [(1<<SEG_W)-1:0]   mm_cfg,
    input  logic [REG_W-1:0]        base_lo,
    input  logic [REG_W-1:0]        base_hi,
    output logic                    xl_on,
    output logic                    bypass,
    output logic [ADDR_W-1:0]       byp_paddr
);
    localparam int OFF_W = ADDR_W - SEG_W;

    logic [SEG_W-1:0] seg;
    logic [SEG_W-1:0] nib;
    logic             seg_hit;

    assign seg     = vaddr[ADDR_W-1 -: SEG_W];
    assign xl_on   = |(gc_cfg & EN_MASK[CFG_W-1:0]);
    assign seg_hit = !user && mm_cfg[seg];
    assign bypass  = !xl_on || seg_hit;

    seg_base_pick #(.SEG_W(SEG_W), .REG_W(REG_W)) i_pick (
        .seg     (seg),
        .base_lo (base_lo),
        .base_hi (base_hi),
        .nibble  (nib)
    );

    always_comb begin
        if (xl_on) byp_paddr = {nib, vaddr[OFF_W-1:0]};
        else       byp_paddr = vaddr;
    end

endmodule

// File: rtl/xlate_fsm.sv
module xlate_fsm
    import xl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bypass,
    input  logic tlb_done,
    output logic req_ready,
    output logic tlb_req,
    output logic rsp_valid,
    output logic accept,
    output logic capture
);
    xl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = bypass ? ST_DONE : ST_WALK;
            ST_WALK: if (tlb_done)  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        tlb_req   = 1'b0;
        rsp_valid = 1'b0;
        accept    = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_WALK: begin
                tlb_req = 1'b1;
                capture = tlb_done;
            end
            ST_DONE: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // R6
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    rsp_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R7
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req && !tlb_done) |=> tlb_req);

endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
    import xl_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          SEG_W   = 4,
    parameter int          REG_W   = 32,
    parameter int          CFG_W   = 32,
    parameter int          KIND_W  = 2,
    parameter logic [31:0] EN_MASK = 32'h0000_000C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_vaddr,
    input  logic                   req_user,
    input  logic [KIND_W-1:0]      req_kind,
    input  logic [CFG_W-1:0]       gc_cfg,
    input  logic [(1<<SEG_W)-1:0]  mm_cfg,
    input  logic [REG_W-1:0]       seg_base_lo,
    input  logic [REG_W-1:0]       seg_base_hi,
    output logic                   tlb_req,
    output logic [ADDR_W-1:0]      tlb_vaddr,
    output logic                   tlb_user,
    output logic [KIND_W-1:0]      tlb_kind,
    input  logic                   tlb_done,
    input  logic [ADDR_W-1:0]      tlb_paddr,
    input  logic [2:0]             tlb_perm,
    input  logic                   tlb_fault,
    output logic                   rsp_valid,
    output logic [ADDR_W-1:0]      rsp_paddr,
    output logic [2:0]             rsp_perm,
    output logic                   rsp_fault,
    output logic                   rsp_from_tlb
);
    logic              xl_on;
    logic              bypass;
    logic [ADDR_W-1:0] byp_paddr;
    logic              accept;
    logic              capture;

    logic [ADDR_W-1:0] hold_vaddr_q;
    logic              hold_user_q;
    logic [KIND_W-1:0] hold_kind_q;
    logic [ADDR_W-1:0] paddr_q;
    perm_t             perm_q;
    logic              fault_q;
    logic              src_q;

    seg_decode #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .REG_W(REG_W),
        .CFG_W(CFG_W), .EN_MASK(EN_MASK)
    ) i_dec (
        .vaddr     (req_vaddr),
        .user      (req_user),
        .gc_cfg    (gc_cfg),
        .mm_cfg    (mm_cfg),
        .base_lo   (seg_base_lo),
        .base_hi   (seg_base_hi),
        .xl_on     (xl_on),
        .bypass    (bypass),
        .byp_paddr (byp_paddr)
    );

    xlate_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bypass    (bypass),
        .tlb_done  (tlb_done),
        .req_ready (req_ready),
        .tlb_req   (tlb_req),
        .rsp_valid (rsp_valid),
        .accept    (accept),
        .capture   (capture)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vaddr_q <= '0;
            hold_user_q  <= 1'b0;
            hold_kind_q  <= '0;
        end else if (accept) begin
            hold_vaddr_q <= req_vaddr;
            hold_user_q  <= req_user;
            hold_kind_q  <= req_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q <= '0;
            perm_q  <= '0;
            fault_q <= 1'b0;
            src_q   <= 1'b0;
        end else if (accept && bypass) begin
            paddr_q <= byp_paddr;
            perm_q  <= PERM_ALL;
            fault_q <= 1'b0;
            src_q   <= 1'b0;
        end else if (capture) begin
            paddr_q <= tlb_paddr;
            perm_q  <= perm_t'(tlb_perm);
            fault_q <= tlb_fault;
            src_q   <= 1'b1;
        end
    end

    assign tlb_vaddr    = hold_vaddr_q;
    assign tlb_user     = hold_user_q;
    assign tlb_kind     = hold_kind_q;
    assign rsp_paddr    = paddr_q;
    assign rsp_perm     = perm_q;
    assign rsp_fault    = fault_q;
    assign rsp_from_tlb = src_q;

    // R1
    off_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_on) |=>
        (rsp_valid && !rsp_from_tlb && rsp_paddr == $past(req_vaddr)));

    // R2
    direct_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xl_on && !req_user
         && mm_cfg[req_vaddr[ADDR_W-1 -: SEG_W]]) |=> (rsp_valid && !rsp_from_tlb && !tlb_req));

    // R3
    direct_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_from_tlb) |-> (rsp_perm == 3'b111 && !rsp_fault));

    // R4
    user_paged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xl_on && req_user) |=> tlb_req);

    // R5
    kern_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xl_on && !req_user
         && !mm_cfg[req_vaddr[ADDR_W-1 -: SEG_W]]) |=> tlb_req);

    // R7
    walk_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req && $past(tlb_req)) |-> ($stable(tlb_vaddr) && $stable(tlb_kind)));

    // R7
    tlb_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_from_tlb) |->
        ($past(tlb_done) && rsp_paddr == $past(tlb_paddr) && rsp_fault == $past(tlb_fault)));

endmodule

// File: tb/test_seg_xlate_front.sv
module test_seg_xlate_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] gc_cfg = '0;
    logic [15:0] mm_cfg = '0;
    logic [31:0] seg_base_lo = '0;
    logic [31:0] seg_base_hi = '0;
    logic        tlb_req;
    logic [31:0] tlb_vaddr;
    logic        tlb_user;
    logic [1:0]  tlb_kind;
    logic        tlb_done = 1'b0;
    logic [31:0] tlb_paddr;
    logic [2:0]  tlb_perm;
    logic        tlb_fault;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic        rsp_fault;
    logic        rsp_from_tlb;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    bit    run_chk = 1'b0;
    string cur_tag = "R8";
    int    stub_wait = 0;
    int    stub_cnt = 0;
    bit    stray = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_front i_seg_xlate_front (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_user(req_user), .req_kind(req_kind),
        .gc_cfg(gc_cfg), .mm_cfg(mm_cfg),
        .seg_base_lo(seg_base_lo), .seg_base_hi(seg_base_hi),
        .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr), .tlb_user(tlb_user), .tlb_kind(tlb_kind),
        .tlb_done(tlb_done), .tlb_paddr(tlb_paddr), .tlb_perm(tlb_perm), .tlb_fault(tlb_fault),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
        .rsp_fault(rsp_fault), .rsp_from_tlb(rsp_from_tlb)
    );

    // TLB stub: a result derived from the pending address, after stub_wait cycles
    assign tlb_paddr = ~tlb_vaddr;
    assign tlb_perm  = tlb_vaddr[2:0];
    assign tlb_fault = tlb_vaddr[12];

    always @(negedge clk) begin
        if (stray) begin
            tlb_done = 1'b1;
        end else if (tlb_req && !tlb_done) begin
            if (stub_cnt == stub_wait) tlb_done = 1'b1;
            else stub_cnt++;
        end else begin
            tlb_done = 1'b0;
            stub_cnt = 0;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: route and address of a request
    function automatic bit ref_paged(input logic [31:0] va, input logic u, output logic [31:0] pa);
        int          s;
        logic [31:0] base;
        logic [3:0]  nib;
        pa = va;
        if ((gc_cfg & 32'hC) == 0) return 1'b0;
        s = int'(va >> 28);
        if (!u && mm_cfg[s]) begin
            base = (s < 8) ? seg_base_lo : seg_base_hi;
            nib  = 4'((base >> ((s % 8) * 4)) & 32'hF);
            pa   = {nib, va[27:0]};
            return 1'b0;
        end
        return 1'b1;
    endfunction

    int          m_ph = 0;
    string       m_tag = "R8";
    logic [31:0] m_va;
    logic        m_us;
    logic [1:0]  m_kd;
    logic [31:0] e_pa;
    logic [2:0]  e_perm;
    logic        e_flt;
    logic        e_src;

    always @(posedge clk) begin
        logic [31:0] pa;
        if (!rst_n) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_tag = cur_tag; m_va = req_vaddr; m_us = req_user; m_kd = req_kind;
                    if (ref_paged(req_vaddr, req_user, pa)) begin
                        m_ph = 1;
                    end else begin
                        m_ph = 2; e_pa = pa; e_perm = 3'b111; e_flt = 1'b0; e_src = 1'b0;
                    end
                end
                1: if (tlb_done) begin
                    m_ph = 2; e_pa = tlb_paddr; e_perm = tlb_perm; e_flt = tlb_fault; e_src = 1'b1;
                end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        string tv;
        if (rst_n && run_chk) begin
            if (m_ph == 0) tv = cur_tag;
            else if (m_ph == 1 || e_src) tv = "R7";
            else tv = "R6";
            chk("R8", "req_ready", 32'(req_ready), 32'(m_ph == 0));
            chk(tv, "rsp_valid", 32'(rsp_valid), 32'(m_ph == 2));
            chk((m_ph == 0) ? cur_tag : m_tag, "tlb_req", 32'(tlb_req), 32'(m_ph == 1));
            if (m_ph == 1) begin
                chk("R7", "tlb_vaddr", tlb_vaddr, m_va);
                chk("R7", "tlb_user", 32'(tlb_user), 32'(m_us));
                chk("R7", "tlb_kind", 32'(tlb_kind), 32'(m_kd));
            end
            if (m_ph == 2) begin
                chk(m_tag, "rsp_paddr", rsp_paddr, e_pa);
                chk(m_tag, "rsp_perm", 32'(rsp_perm), 32'(e_perm));
                chk(m_tag, "rsp_fault", 32'(rsp_fault), 32'(e_flt));
                chk(m_tag, "rsp_from_tlb", 32'(rsp_from_tlb), 32'(e_src));
            end
        end
    end

    task automatic issue(input logic [31:0] va, input logic u, input logic [1:0] k,
                         input int w, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_tag = tag; stub_wait = w;
        req_vaddr = va; req_user = u; req_kind = k; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8", "reset req_ready", 32'(req_ready), 32'd1);
        chk("R8", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R8", "reset tlb_req", 32'(tlb_req), 32'd0);
        rst_n = 1'b1;
        run_chk = 1'b1;

        seg_base_lo = 32'h7A3C_51E9;
        seg_base_hi = 32'hB2D4_0F68;
        mm_cfg      = 16'h8181;

        // R1: translation off, identity with full rights for both modes
        gc_cfg = 32'h0;
        issue(32'h3456_789A, 1'b0, 2'd0, 0, "R1");
        issue(32'hF000_0004, 1'b1, 2'd1, 0, "R1");
        gc_cfg = 32'hFFFF_FFF3;
        issue(32'h8000_0010, 1'b0, 2'd0, 0, "R1");
        // R1: either enable bit alone turns translation on
        gc_cfg = 32'h4;
        issue(32'h0000_1000, 1'b1, 2'd0, 2, "R1");
        gc_cfg = 32'h8;
        issue(32'h1234_5678, 1'b1, 2'd2, 1, "R1");

        // R2 / R3: direct-mapped kernel segments, both registers, boundaries
        issue(32'h0ABC_DEF0, 1'b0, 2'd0, 0, "R2");
        issue(32'h7FFF_FFFF, 1'b0, 2'd1, 0, "R3");
        issue(32'h8000_0000, 1'b0, 2'd2, 0, "R3");
        issue(32'hF123_4567, 1'b0, 2'd0, 0, "R3");

        // R5: kernel, segment bit clear
        issue(32'h3000_2000, 1'b0, 2'd0, 0, "R5");
        issue(32'hE000_1008, 1'b0, 2'd1, 3, "R5");
        mm_cfg = 16'h0001;
        issue(32'h7000_0005, 1'b0, 2'd2, 1, "R5");
        issue(32'h0000_0040, 1'b0, 2'd0, 0, "R2");
        mm_cfg = 16'h8181;

        // R4: user in a mapped segment goes to the TLB
        issue(32'h0000_4000, 1'b1, 2'd0, 1, "R4");
        issue(32'hF00F_F007, 1'b1, 2'd2, 0, "R4");

        // R7: paged handshake with varied waits and kinds
        issue(32'h5555_3003, 1'b1, 2'd1, 6, "R7");
        issue(32'h2AAA_0006, 1'b0, 2'd2, 0, "R7");

        // R6: back-to-back bypass requests
        issue(32'h8765_4321, 1'b0, 2'd0, 0, "R6");
        issue(32'h0000_0001, 1'b0, 2'd0, 0, "R6");

        // R8: request raised during a walk is ignored
        @(negedge clk);
        cur_tag = "R8"; stub_wait = 4;
        req_vaddr = 32'h4444_0000; req_user = 1'b1; req_kind = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        req_vaddr = 32'h8000_0123; req_user = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);

        // R9: stray TLB done while idle
        cur_tag = "R9";
        @(negedge clk);
        stray = 1'b1;
        @(negedge clk);
        stray = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "ready after stray done", 32'(req_ready), 32'd1);

        issue(32'hF000_0000, 1'b0, 2'd0, 0, "R3");
        repeat (3) @(negedge clk);
        summary();
    end

endmodule